// File: doc/BRIEF.md
# Shift, Add and Flag Datapath

This block is the purely combinational arithmetic slice of a small 16-bit-encoded RISC core. A decoder upstream picks an operation code and presents two 32-bit operands, a 5-bit shift count and an 8-bit constant, along with the flag word currently held by the core. In the same cycle, the block returns the 32-bit result, the flag word to store next, and a write enable for the destination register.

The block supports three immediate shifts (logical left, logical right, arithmetic right), add, subtract, compare and a constant load. A shift count of zero means something different for each shift. A left shift by zero is a plain move that leaves carry alone. A right shift by zero, logical or arithmetic, stands for a shift of 32. Each operation rewrites only its own set of flags and passes the others through from `flags_in`. The flag word is packed as N at bit 3, Z at bit 2, C at bit 1 and V at bit 0.

Top module: `shift_add_flag_unit`

## Requirements
- R1: For every operation code except 7, flag N (bit 3) equals result bit 31, and flag Z (bit 2) is 1 exactly when all 32 result bits are zero.
- R2: Code 3 (add) returns a+b modulo 2^32. C is the carry out of bit 31, and V is set when the signed sum overflows.
- R3: Code 4 (subtract) returns a-b modulo 2^32. C is 1 when a >= b as unsigned values (no borrow), V flags signed overflow, and the write enable is 1.
- R4: Code 5 (compare) produces the same N, Z, C and V as subtract but holds the write enable at 0.
- R5: Code 0 (logical left) with count 0 returns operand a unchanged and passes C through from flags_in.
- R6: Code 0 with count n in 1..31 returns a shifted left by n, with C = a[32-n].
- R7: Code 1 (logical right) with count 0 acts as a 32-place shift: the result is 0 and C = a[31].
- R8: Code 1 with count n in 1..31 returns a logically shifted right by n, with C = a[n-1].
- R9: Code 2 (arithmetic right) with count 0 fills the result with a[31] and sets C = a[31]. With count n in 1..31 it shifts right by n with sign fill and sets C = a[n-1].
- R10: Codes 0, 1, 2 and 6 always pass V through from flags_in.
- R11: Code 6 (constant load) returns the 8-bit constant zero-extended to 32 bits and passes both C and V through.
- R12: Code 7 (reserved) returns result 0 with the write enable at 0 and flags_out equal to flags_in.
- R13: The write enable is 1 for codes 0, 1, 2, 3, 4 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code: 0 lsl, 1 lsr, 2 asr, 3 add, 4 sub, 5 cmp, 6 load constant, 7 reserved |
| opnd_a | input | 32 | First operand; shift source |
| opnd_b | input | 32 | Second operand for add, subtract and compare |
| shamt | input | 5 | Immediate shift count |
| imm | input | 8 | Constant for the load operation |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Operation result |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| wr_en | output | 1 | Destination write enable |

## Verification
The block holds no state, so any fault shows up at the ports in the same evaluation as the inputs that trigger it. A bad zero-count decode shows up as a wrong result or a wrong C on exactly those shift vectors. A flag-mask error shows up as a changed C or V that should have passed through. A sign error in the subtractor shows up as a wrong C or V on operands that straddle the unsigned or signed boundary. The stimulus therefore sets flags_in to values opposite to what the operation would produce, so a wrongly rewritten flag is visible on the very vector that causes it.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

    typedef enum logic [2:0] {
        OPC_SHL = 3'd0,
        OPC_SHR = 3'd1,
        OPC_SAR = 3'd2,
        OPC_ADD = 3'd3,
        OPC_SUB = 3'd4,
        OPC_CMP = 3'd5,
        OPC_LDI = 3'd6,
        OPC_RSV = 3'd7
    } opc_e;

    // packed so that neg is the most significant bit
    typedef struct packed {
        logic neg;
        logic zero;
        logic cry;
        logic ovf;
    } flags_t;

endpackage

// File: rtl/sfu_shifter.sv
module sfu_shifter
    import sfu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SH_W   = 5
) (
    input  opc_e              opc,
    input  logic [DATA_W-1:0] src,
    input  logic [SH_W-1:0]   amt,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int unsigned CNT_W = SH_W + 1;
    localparam int unsigned EXT_W = 2 * DATA_W + 1;

    logic [CNT_W-1:0]  eff;
    logic              fill;
    logic [DATA_W:0]   ext_l;
    logic [EXT_W-1:0]  ext_src;
    logic [DATA_W:0]   ext_r;

    // a zero count on a right shift stands for a full-width shift
    always_comb begin
        eff = {1'b0, amt};
        if (amt == '0 && opc != OPC_SHL) begin
            eff = CNT_W'(DATA_W);
        end
        fill    = (opc == OPC_SAR) ? src[DATA_W-1] : 1'b0;
        ext_l   = {1'b0, src} << eff;
        ext_src = {{DATA_W{fill}}, src, 1'b0};
        ext_r   = (DATA_W+1)'(ext_src >> eff);
    end

    always_comb begin
        if (opc == OPC_SHL) begin
            res  = ext_l[DATA_W-1:0];
            cout = (amt == '0) ? cin : ext_l[DATA_W];
        end else begin
            res  = ext_r[DATA_W:1];
            cout = ext_r[0];
        end
    end

    always_comb begin
        if (opc == OPC_SHL && amt == '0) begin
            p_shl_zero_r5: assert (res == src && cout == cin)
                else $error("left shift by zero altered operand or carry");
        end
        if (opc == OPC_SHR && amt == '0) begin
            p_shr_full_r7: assert (res == '0 && cout == src[DATA_W-1])
                else $error("logical right by zero not a full shift");
        end
        if (opc == OPC_SAR && amt == '0) begin
            p_sar_full_r9: assert (res == {DATA_W{src[DATA_W-1]}})
                else $error("arithmetic right by zero not sign filled");
        end
    end

endmodule

// File: rtl/sfu_addsub.sv
module sfu_addsub #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              sub,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);
    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;

    // subtract is a + ~b + 1; carry out then means "no borrow"
    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
        sum   = wide[DATA_W-1:0];
        cout  = wide[DATA_W];
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end

    always_comb begin
        if (sub) begin
            p_noborrow_r3: assert (cout == (a >= b))
                else $error("subtract carry disagrees with unsigned compare");
        end else begin
            p_carry_r2: assert (cout == (sum < a))
                else $error("add carry disagrees with wraparound");
        end
    end

endmodule

// File: rtl/shift_add_flag_unit.sv
module shift_add_flag_unit
    import sfu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SH_W   = 5,
    parameter int unsigned IMM_W  = 8
) (
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [SH_W-1:0]   shamt,
    input  logic [IMM_W-1:0]  imm,
    input  logic [3:0]        flags_in,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        flags_out,
    output logic              wr_en
);
    localparam int unsigned MSB   = DATA_W - 1;
    localparam int unsigned PAD_W = DATA_W - IMM_W;

    opc_e              opc;
    flags_t            fin;
    flags_t            fout;
    logic [DATA_W-1:0] sh_res;
    logic              sh_c;
    logic [DATA_W-1:0] as_res;
    logic              as_c;
    logic              as_v;
    logic              as_sub;

    assign opc    = opc_e'(op_sel);
    assign fin    = flags_t'(flags_in);
    assign as_sub = (opc == OPC_SUB) || (opc == OPC_CMP);

    sfu_shifter #(
        .DATA_W (DATA_W),
        .SH_W   (SH_W)
    ) u_shift (
        .opc  (opc),
        .src  (opnd_a),
        .amt  (shamt),
        .cin  (fin.cry),
        .res  (sh_res),
        .cout (sh_c)
    );

    sfu_addsub #(
        .DATA_W (DATA_W)
    ) u_addsub (
        .sub  (as_sub),
        .a    (opnd_a),
        .b    (opnd_b),
        .sum  (as_res),
        .cout (as_c),
        .ovf  (as_v)
    );

    always_comb begin
        result = '0;
        fout   = fin;
        wr_en  = 1'b1;
        unique case (opc)
            OPC_SHL, OPC_SHR, OPC_SAR: begin
                result   = sh_res;
                fout.cry = sh_c;
            end
            OPC_ADD, OPC_SUB: begin
                result   = as_res;
                fout.cry = as_c;
                fout.ovf = as_v;
            end
            OPC_CMP: begin
                result   = as_res;
                fout.cry = as_c;
                fout.ovf = as_v;
                wr_en    = 1'b0;
            end
            OPC_LDI: begin
                result = {{PAD_W{1'b0}}, imm};
            end
            OPC_RSV: begin
                wr_en = 1'b0;
            end
        endcase
        if (opc != OPC_RSV) begin
            fout.neg  = result[MSB];
            fout.zero = (result == '0);
        end
    end

    assign flags_out = fout;

    always_comb begin
        if (opc != OPC_RSV) begin
            p_neg_bit_r1: assert (flags_out[3] == result[MSB])
                else $error("N does not follow result sign");
            p_zero_bit_r1: assert (flags_out[2] == ~|result)
                else $error("Z does not follow result");
        end
        if (opc == OPC_CMP) begin
            p_cmp_nowrite_r4: assert (!wr_en)
                else $error("compare requested a write");
        end
        if (opc == OPC_SHL || opc == OPC_SHR || opc == OPC_SAR || opc == OPC_LDI) begin
            p_v_kept_r10: assert (flags_out[0] == flags_in[0])
                else $error("V changed by shift or constant load");
        end
        if (opc == OPC_LDI) begin
            p_ldi_c_kept_r11: assert (flags_out[1] == flags_in[1])
                else $error("C changed by constant load");
        end
        if (opc == OPC_RSV) begin
            p_rsv_idle_r12: assert (!wr_en && flags_out == flags_in && result == '0)
                else $error("reserved code had an effect");
        end
    end

endmodule

// File: tb/test_shift_add_flag_unit.sv
module test_shift_add_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  shamt = '0;
    logic [7:0]  imm = '0;
    logic [3:0]  flags_in = '0;
    logic [31:0] result;
    logic [3:0]  flags_out;
    logic        wr_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    shift_add_flag_unit i_shift_add_flag_unit (
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .shamt     (shamt),
        .imm       (imm),
        .flags_in  (flags_in),
        .result    (result),
        .flags_out (flags_out),
        .wr_en     (wr_en)
    );

    typedef struct packed {
        logic [31:0] res;
        logic [3:0]  flg;
        logic        wr;
    } exp_t;

    function automatic exp_t model(input logic [2:0] op, input logic [31:0] a,
                                   input logic [31:0] b, input logic [4:0] sh,
                                   input logic [7:0] k, input logic [3:0] fi);
        exp_t e;
        int n;
        logic [32:0] s;
        logic c, v;
        e.res = '0; e.wr = 1'b1; c = fi[1]; v = fi[0];
        n = (sh == 0) ? 32 : int'(sh);
        case (op)
            3'd0: if (sh != 0) begin e.res = a << sh; c = a[32 - int'(sh)]; end
                  else e.res = a;
            3'd1: begin e.res = (n == 32) ? 32'd0 : a >> n; c = a[n-1]; end
            3'd2: begin e.res = $unsigned($signed(a) >>> n); c = a[n-1]; end
            3'd3: begin
                s = {1'b0, a} + {1'b0, b}; e.res = s[31:0]; c = s[32];
                v = (a[31] == b[31]) && (s[31] != a[31]);
            end
            3'd4, 3'd5: begin
                e.res = a - b; c = (a >= b);
                v = (a[31] != b[31]) && (e.res[31] != a[31]);
                e.wr = (op == 3'd4);
            end
            3'd6: e.res = {24'd0, k};
            default: e.wr = 1'b0;
        endcase
        if (op == 3'd7) e.flg = fi;
        else e.flg = {e.res[31], (e.res == 0), c, v};
        return e;
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic [4:0] sh);
        case (op)
            3'd0: return (sh == 0) ? "R5" : "R6";
            3'd1: return (sh == 0) ? "R7" : "R8";
            3'd2: return "R9";
            3'd3: return "R2";
            3'd4: return "R3";
            3'd5: return "R4";
            3'd6: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh, input logic [7:0] k, input logic [3:0] fi);
        exp_t e;
        string t;
        @(posedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; shamt = sh; imm = k; flags_in = fi;
        @(negedge clk);
        e = model(op, a, b, sh, k, fi);
        t = tag_of(op, sh);
        check(t, "result", result, e.res);
        check(t, "carry", 32'(flags_out[1]), 32'(e.flg[1]));
        if (op == 3'd7) begin
            check("R12", "flags", 32'(flags_out), 32'(e.flg));
            check("R12", "wr_en", 32'(wr_en), 32'd0);
        end else begin
            check("R1", "N/Z", 32'(flags_out[3:2]), 32'(e.flg[3:2]));
            if (op == 3'd0 || op == 3'd1 || op == 3'd2 || op == 3'd6)
                check("R10", "V kept", 32'(flags_out[0]), 32'(fi[0]));
            else
                check(t, "V", 32'(flags_out[0]), 32'(e.flg[0]));
            check((op == 3'd5) ? "R4" : "R13", "wr_en", 32'(wr_en), 32'(e.wr));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: zero inputs give a zero left shift with Z set
        check("R5", "reset result", result, 32'd0);
        check("R1", "reset flags", 32'(flags_out), 32'h4);
        rst_n = 1'b1;

        run(3'd3, 32'h7fff_ffff, 32'd1, 5'd0, 8'd0, 4'h0);
        run(3'd3, 32'hffff_ffff, 32'd1, 5'd0, 8'd0, 4'h1);
        run(3'd3, 32'h8000_0000, 32'h8000_0000, 5'd0, 8'd0, 4'h0);
        run(3'd4, 32'd5, 32'd5, 5'd0, 8'd0, 4'h0);
        run(3'd4, 32'd3, 32'd5, 5'd0, 8'd0, 4'hf);
        run(3'd4, 32'h8000_0000, 32'd1, 5'd0, 8'd0, 4'h0);
        run(3'd5, 32'd9, 32'd4, 5'd0, 8'd0, 4'h1);
        run(3'd5, 32'd4, 32'd9, 5'd0, 8'd0, 4'h0);
        run(3'd0, 32'h8000_0001, 32'd0, 5'd0, 8'd0, 4'h2);
        run(3'd0, 32'h8000_0001, 32'd0, 5'd0, 8'd0, 4'h1);
        run(3'd0, 32'h8000_0001, 32'd0, 5'd1, 8'd0, 4'h1);
        run(3'd0, 32'h0000_0003, 32'd0, 5'd31, 8'd0, 4'h0);
        run(3'd1, 32'h8000_0000, 32'd0, 5'd0, 8'd0, 4'h1);
        run(3'd1, 32'h7fff_ffff, 32'd0, 5'd0, 8'd0, 4'h2);
        run(3'd1, 32'h0000_0003, 32'd0, 5'd1, 8'd0, 4'h0);
        run(3'd1, 32'hc000_0000, 32'd0, 5'd31, 8'd0, 4'h0);
        run(3'd2, 32'h8000_0000, 32'd0, 5'd0, 8'd0, 4'h1);
        run(3'd2, 32'h4000_0000, 32'd0, 5'd0, 8'd0, 4'h3);
        run(3'd2, 32'hf000_0018, 32'd0, 5'd4, 8'd0, 4'h0);
        run(3'd6, 32'hdead_beef, 32'd0, 5'd7, 8'hff, 4'h3);
        run(3'd6, 32'hdead_beef, 32'd0, 5'd0, 8'h00, 4'h8);
        run(3'd7, 32'h1234_5678, 32'h1, 5'd3, 8'h5, 4'ha);

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            if (i % 7 == 0) rb = ra;
            run(3'($urandom()), ra, rb, 5'($urandom()), 8'($urandom()), 4'($urandom()));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule